// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block steps a phase-locked loop from its present divider settings to a new set without letting a glitching clock reach downstream logic. A request carries four divider fields: the input divider, the output divider, the feedback multiplier and the bandwidth field. The sequencer first parks the clock-selection mux on the slow reference if it was on the PLL output. It then pulses the PLL reset around the register write and waits a settle time that grows with the input divider. After that it polls the lock indication under a cycle bound.

When lock never arrives within the bound, the sequencer makes one more pass with the settings it saved at the start of the request. It reports an error whether or not that pass succeeds. A pass that was itself a rollback never starts another one. At the end of every request the mux selection is handed back unchanged, and a one-cycle done pulse closes the request.

A neighbouring register supplies the mux field on `mode_i`. The sequencer overrides it on `mode_o` only while parked. The analog PLL and the choice of divider values belong to the surrounding design.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `err_o` and `pll_rst_o` are low, the divider outputs hold the INIT_* parameter values, and `mode_o` equals `mode_i`.
- R2: A request (`req_valid_i` high in a cycle where `busy_o` is low) raises `busy_o` from the next cycle through the done cycle. Requests presented while `busy_o` is high have no effect on the divider outputs.
- R3: The mux field uses 0 = slow reference, 1 = PLL output, 2 = deep slow. If `mode_i` is 1 when a request is accepted, `mode_o` reads 0 from the next cycle until the done cycle, including any rollback pass. In the done cycle it equals `mode_i` again.
- R4: If `mode_i` is not 1 when a request is accepted, `mode_o` equals `mode_i` throughout the request.
- R5: Each pass holds `pll_rst_o` high for exactly two consecutive cycles. The divider outputs change only while `pll_rst_o` is high.
- R6: The input divider field is stored as ratio minus one. After reset is released the block waits D = ((field+1)*500)/24 + 1 cycles, during which lock is not sampled. With lock already high, done arrives 4 + D cycles after the accepting edge.
- R7: If lock is first seen on poll cycle L, where L counts from 0 and may be at most TIMEOUT-1, done pulses for one cycle at edge 4 + D + L. `err_o` stays low and the outputs hold the requested dividers.
- R8: After TIMEOUT poll cycles without lock, the settings saved at acceptance are written back in a second pass. If that pass locks at once, done arrives at edge 7 + D + TIMEOUT + D0, where D0 is the settle time of the saved input divider. `err_o` is high with done.
- R9: A timeout during the rollback pass ends the request with no further pass, at edge 6 + D + D0 + 2*TIMEOUT. `err_o` is high and the saved settings stay on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Start a reprogramming request |
| req_nr_i | input | NR_W | Requested input divider (ratio minus one) |
| req_no_i | input | NO_W | Requested output divider |
| req_nf_i | input | NF_W | Requested feedback multiplier |
| req_nb_i | input | NB_W | Requested bandwidth field |
| mode_i | input | 2 | Mux selection from the owning register |
| lock_i | input | 1 | PLL lock indication |
| mode_o | output | 2 | Mux selection applied to the clock mux |
| pll_rst_o | output | 1 | PLL reset |
| cfg_nr_o | output | NR_W | Applied input divider |
| cfg_no_o | output | NO_W | Applied output divider |
| cfg_nf_o | output | NF_W | Applied feedback multiplier |
| cfg_nb_o | output | NB_W | Applied bandwidth field |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | Lock timeout occurred; valid with done_o |

## Verification
The checker watches these properties on every cycle:
- the reset pulse is exactly two cycles and never occurs while idle;
- the dividers change only under reset;
- the mux output stays steady for the whole request and only ever shows slow or the passed-through value;
- done is a single pulse followed by idle, and never comes right after reset;
- the error flag appears only with done.

The settle delay arithmetic, the exact poll count that causes a timeout, the values restored by rollback and the single-rollback limit all depend on cycle counts and stored values. Only the bench scenarios can show them. The bench does this by timing each request from acceptance to done against the formulas and comparing the final dividers with its own model.

// File: rtl/pll_seq_pkg.sv
`timescale 1ns/1ps
package pll_seq_pkg;

   localparam logic [1:0] MODE_SLOW   = 2'd0;
   localparam logic [1:0] MODE_NORMAL = 2'd1;
   localparam logic [1:0] MODE_DEEP   = 2'd2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PARK,
      ST_RST,
      ST_LOAD,
      ST_SETTLE,
      ST_POLL,
      ST_FIN
   } seq_st_e;

endpackage

// File: rtl/pll_seq_bank.sv
`timescale 1ns/1ps
// Divider storage: applied set, saved set for rollback, and staged target.
module pll_seq_bank #(
   parameter int NR_W    = 6,
   parameter int NO_W    = 4,
   parameter int NF_W    = 13,
   parameter int NB_W    = 12,
   parameter int INIT_NR = 0,
   parameter int INIT_NO = 1,
   parameter int INIT_NF = 99,
   parameter int INIT_NB = 49
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap_en,
   input  logic            rb_en,
   input  logic            wr_en,
   input  logic [NR_W-1:0] req_nr,
   input  logic [NO_W-1:0] req_no,
   input  logic [NF_W-1:0] req_nf,
   input  logic [NB_W-1:0] req_nb,
   output logic [NR_W-1:0] cfg_nr,
   output logic [NO_W-1:0] cfg_no,
   output logic [NF_W-1:0] cfg_nf,
   output logic [NB_W-1:0] cfg_nb
);
   localparam int CW     = NR_W + NO_W + NF_W + NB_W;
   localparam int NB_LO  = 0;
   localparam int NF_LO  = NB_LO + NB_W;
   localparam int NO_LO  = NF_LO + NF_W;
   localparam int NR_LO  = NO_LO + NO_W;
   localparam logic [CW-1:0] INIT_V = {NR_W'(INIT_NR), NO_W'(INIT_NO),
                                       NF_W'(INIT_NF), NB_W'(INIT_NB)};

   logic [CW-1:0] cfg_q, snap_q, tgt_q, req_v;

   assign req_v = {req_nr, req_no, req_nf, req_nb};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= INIT_V;
         snap_q <= INIT_V;
         tgt_q  <= INIT_V;
      end else begin
         if (cap_en) begin
            tgt_q  <= req_v;
            snap_q <= cfg_q;
         end else if (rb_en) begin
            tgt_q  <= snap_q;
         end
         if (wr_en) begin
            cfg_q <= tgt_q;
         end
      end
   end

   assign cfg_nr = cfg_q[NR_LO +: NR_W];
   assign cfg_no = cfg_q[NO_LO +: NO_W];
   assign cfg_nf = cfg_q[NF_LO +: NF_W];
   assign cfg_nb = cfg_q[NB_LO +: NB_W];

endmodule

// File: rtl/pll_seq_settle.sv
`timescale 1ns/1ps
// Post-reset settle timer; length derived from the input divider.
module pll_seq_settle #(
   parameter int NR_W        = 6,
   parameter int RESET_STYLE = 1,
   parameter int UNIT_MUL    = 500,
   parameter int UNIT_DIV    = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic [NR_W-1:0] nr_i,
   output logic            last_o
);
   localparam int DLY_MAX = ((2 ** NR_W) * UNIT_MUL) / UNIT_DIV + 1;
   localparam int DLY_W   = $clog2(DLY_MAX + 1);

   logic [DLY_W-1:0] dly, cnt_q;

   generate
      if (RESET_STYLE != 0) begin : g_scaled
         localparam int PW = NR_W + 1 + $clog2(UNIT_MUL + 1);
         logic [PW-1:0] prod, quo;
         always_comb begin
            prod = (PW'(nr_i) + PW'(1)) * PW'(UNIT_MUL);
            quo  = prod / PW'(UNIT_DIV);
            dly  = DLY_W'(quo) + DLY_W'(1);
         end
      end else begin : g_fixed
         assign dly = DLY_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= dly;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - DLY_W'(1);
      end
   end

   assign last_o = (cnt_q == DLY_W'(1));

endmodule

// File: rtl/pll_seq_lockwait.sv
`timescale 1ns/1ps
// Bounded lock poll: counts unlocked poll cycles up to TIMEOUT.
module pll_seq_lockwait #(
   parameter int TIMEOUT = 24_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic lock_i,
   output logic hit_o,
   output logic expire_o
);
   localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT + 1) : 1;
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (!lock_i) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign hit_o    = run_i & lock_i;
   assign expire_o = run_i & ~lock_i & (cnt_q == LAST);

endmodule

// File: rtl/pll_reprog_seq.sv
`timescale 1ns/1ps
module pll_reprog_seq
   import pll_seq_pkg::*;
#(
   parameter int NR_W        = 6,
   parameter int NO_W        = 4,
   parameter int NF_W        = 13,
   parameter int NB_W        = 12,
   parameter int INIT_NR     = 0,
   parameter int INIT_NO     = 1,
   parameter int INIT_NF     = 99,
   parameter int INIT_NB     = 49,
   parameter int RESET_STYLE = 1,
   parameter int TIMEOUT     = 24_000_000,
   parameter int UNIT_MUL    = 500,
   parameter int UNIT_DIV    = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid_i,
   input  logic [NR_W-1:0] req_nr_i,
   input  logic [NO_W-1:0] req_no_i,
   input  logic [NF_W-1:0] req_nf_i,
   input  logic [NB_W-1:0] req_nb_i,
   input  logic [1:0]      mode_i,
   input  logic            lock_i,
   output logic [1:0]      mode_o,
   output logic            pll_rst_o,
   output logic [NR_W-1:0] cfg_nr_o,
   output logic [NO_W-1:0] cfg_no_o,
   output logic [NF_W-1:0] cfg_nf_o,
   output logic [NB_W-1:0] cfg_nb_o,
   output logic            busy_o,
   output logic            done_o,
   output logic            err_o
);
   localparam seq_st_e ST_AFTER_PARK = (RESET_STYLE != 0) ? ST_RST : ST_LOAD;

   generate
      if (NR_W < 1 || NO_W < 1 || NF_W < 1 || NB_W < 1) begin : g_bad_w
         $error("pll_reprog_seq: divider widths must be positive");
      end
      if (TIMEOUT < 1) begin : g_bad_to
         $error("pll_reprog_seq: TIMEOUT must be at least 1");
      end
      if (UNIT_DIV < 1) begin : g_bad_div
         $error("pll_reprog_seq: UNIT_DIV must be at least 1");
      end
   endgenerate

   seq_st_e st_q;
   logic    park_q, rb_q, err_q;
   logic    cap_en, rb_en, wr_en, settle_load, settle_last;
   logic    poll_run, poll_hit, poll_expire;

   assign cap_en      = (st_q == ST_IDLE) && req_valid_i;
   assign poll_run    = (st_q == ST_POLL);
   assign rb_en       = poll_expire && !rb_q;
   assign wr_en       = (st_q == ST_RST) || ((st_q == ST_PARK) && (RESET_STYLE == 0));
   assign settle_load = (st_q == ST_LOAD);

   pll_seq_bank #(
      .NR_W(NR_W), .NO_W(NO_W), .NF_W(NF_W), .NB_W(NB_W),
      .INIT_NR(INIT_NR), .INIT_NO(INIT_NO), .INIT_NF(INIT_NF), .INIT_NB(INIT_NB)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (cap_en),
      .rb_en  (rb_en),
      .wr_en  (wr_en),
      .req_nr (req_nr_i),
      .req_no (req_no_i),
      .req_nf (req_nf_i),
      .req_nb (req_nb_i),
      .cfg_nr (cfg_nr_o),
      .cfg_no (cfg_no_o),
      .cfg_nf (cfg_nf_o),
      .cfg_nb (cfg_nb_o)
   );

   pll_seq_settle #(
      .NR_W(NR_W), .RESET_STYLE(RESET_STYLE),
      .UNIT_MUL(UNIT_MUL), .UNIT_DIV(UNIT_DIV)
   ) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (settle_load),
      .nr_i   (cfg_nr_o),
      .last_o (settle_last)
   );

   pll_seq_lockwait #(
      .TIMEOUT(TIMEOUT)
   ) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (poll_run),
      .lock_i   (lock_i),
      .hit_o    (poll_hit),
      .expire_o (poll_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         park_q <= 1'b0;
         rb_q   <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  st_q   <= ST_PARK;
                  park_q <= (mode_i == MODE_NORMAL);
                  rb_q   <= 1'b0;
                  err_q  <= 1'b0;
               end
            end
            ST_PARK:   st_q <= ST_AFTER_PARK;
            ST_RST:    st_q <= ST_LOAD;
            ST_LOAD:   st_q <= ST_SETTLE;
            ST_SETTLE: begin
               if (settle_last) st_q <= ST_POLL;
            end
            ST_POLL: begin
               if (poll_hit) begin
                  st_q   <= ST_FIN;
                  park_q <= 1'b0;
               end else if (poll_expire) begin
                  err_q <= 1'b1;
                  if (!rb_q) begin
                     rb_q <= 1'b1;
                     st_q <= ST_PARK;
                  end else begin
                     st_q   <= ST_FIN;
                     park_q <= 1'b0;
                  end
               end
            end
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o    = (st_q != ST_IDLE);
   assign done_o    = (st_q == ST_FIN);
   assign err_o     = (st_q == ST_FIN) && err_q;
   assign pll_rst_o = (RESET_STYLE != 0) && ((st_q == ST_RST) || (st_q == ST_LOAD));
   assign mode_o    = park_q ? MODE_SLOW : mode_i;

endmodule

// File: rtl/pll_reprog_seq_chk.sv
`timescale 1ns/1ps
module pll_reprog_seq_chk #(
   parameter int CW          = 35,
   parameter int RESET_STYLE = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    mode_i,
   input logic [1:0]    mode_o,
   input logic          pll_rst_o,
   input logic [CW-1:0] cfg_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          err_o
);
   AST_RST_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      pll_rst_o |-> busy_o); // R5
   AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_rst_o) |=> pll_rst_o); // R5
   AST_RST_END: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_rst_o && $past(pll_rst_o)) |=> !pll_rst_o); // R5
   AST_CFG_UNDER_RST: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_i) |-> ((RESET_STYLE != 0) ? pll_rst_o : busy_o)); // R5
   AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!pll_rst_o && !$past(pll_rst_o))); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7
   AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o); // R2
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o); // R8
   AST_MODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o && $past(busy_o) && $stable(mode_i)) |-> $stable(mode_o)); // R3
   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (mode_o == 2'd0 || mode_o == mode_i)); // R4
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
   .CW(NR_W + NO_W + NF_W + NB_W),
   .RESET_STYLE(RESET_STYLE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_i    (mode_i),
   .mode_o    (mode_o),
   .pll_rst_o (pll_rst_o),
   .cfg_i     ({cfg_nr_o, cfg_no_o, cfg_nf_o, cfg_nb_o}),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .err_o     (err_o)
);

// File: tb/pll_reprog_seq_tb.sv
`timescale 1ns/1ps
module pll_reprog_seq_tb;
   localparam int TB_TO   = 20;
   localparam int I_NR    = 3;
   localparam int I_NO    = 1;
   localparam int I_NF    = 99;
   localparam int I_NB    = 49;
   localparam int K_LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid_i = 1'b0;
   logic [5:0]  req_nr_i = '0;
   logic [3:0]  req_no_i = '0;
   logic [12:0] req_nf_i = '0;
   logic [11:0] req_nb_i = '0;
   logic [1:0]  mode_i = 2'd1;
   logic        lock_i = 1'b0;
   logic [1:0]  mode_o;
   logic        pll_rst_o;
   logic [5:0]  cfg_nr_o;
   logic [3:0]  cfg_no_o;
   logic [12:0] cfg_nf_o;
   logic [11:0] cfg_nb_o;
   logic        busy_o, done_o, err_o;

   int n_chk = 0;
   int n_fail = 0;

   logic [5:0]  m_nr = 6'(I_NR);
   logic [3:0]  m_no = 4'(I_NO);
   logic [12:0] m_nf = 13'(I_NF);
   logic [11:0] m_nb = 12'(I_NB);

   always #2 clk = ~clk;  // 4 ns period, 250 MHz

   pll_reprog_seq #(
      .NR_W(6), .NO_W(4), .NF_W(13), .NB_W(12),
      .INIT_NR(I_NR), .INIT_NO(I_NO), .INIT_NF(I_NF), .INIT_NB(I_NB),
      .RESET_STYLE(1), .TIMEOUT(TB_TO)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i),
      .req_nr_i(req_nr_i), .req_no_i(req_no_i), .req_nf_i(req_nf_i), .req_nb_i(req_nb_i),
      .mode_i(mode_i), .lock_i(lock_i), .mode_o(mode_o), .pll_rst_o(pll_rst_o),
      .cfg_nr_o(cfg_nr_o), .cfg_no_o(cfg_no_o), .cfg_nf_o(cfg_nf_o), .cfg_nb_o(cfg_nb_o),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
   );

   function automatic int settle_d(input logic [5:0] nr);
      return ((int'(nr) + 1) * 500) / 24 + 1;
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [34:0] cfg_now();
      return {cfg_nr_o, cfg_no_o, cfg_nf_o, cfg_nb_o};
   endfunction

   // kind: 0 lock on poll cycle lat, 1 new fails / old locks, 2 never locks, 3 lock always high
   task automatic run_req(input logic [5:0] nr, input logic [3:0] no, input logic [12:0] nf_in,
                          input logic [11:0] nb, input logic [1:0] md, input int kind,
                          input int lat, input bit spam);
      logic [34:0] oldv, newv, expv;
      logic [12:0] nf;
      int d0, d1, k, ek, rst_cnt, passes;
      bit mode_bad, busy_bad, exp_err;
      string rq;
      nf = nf_in;
      if ((kind == 1 || kind == 2) && nf == m_nf) nf = nf ^ 13'd1;
      oldv = {m_nr, m_no, m_nf, m_nb};
      newv = {nr, no, nf, nb};
      d0 = settle_d(m_nr);
      d1 = settle_d(nr);
      case (kind)
         0: begin ek = 4 + d1 + lat; expv = newv; exp_err = 0; passes = 1; rq = "R7"; end
         1: begin ek = 7 + d1 + TB_TO + d0; expv = oldv; exp_err = 1; passes = 2; rq = "R8"; end
         2: begin ek = 6 + d1 + d0 + 2 * TB_TO; expv = oldv; exp_err = 1; passes = 2; rq = "R9"; end
         default: begin ek = 4 + d1; expv = newv; exp_err = 0; passes = 1; rq = "R6"; end
      endcase
      check(!busy_o && !done_o, "R2", "idle before request", {busy_o, done_o}, 0);
      mode_i = md;
      req_nr_i = nr; req_no_i = no; req_nf_i = nf; req_nb_i = nb;
      req_valid_i = 1'b1;
      lock_i = (kind == 3);
      @(posedge clk);
      @(negedge clk);
      if (spam) begin
         req_nr_i = nr ^ 6'h01;
         req_nf_i = nf ^ 13'h0aa;
      end else begin
         req_valid_i = 1'b0;
      end
      k = 0; rst_cnt = 0; mode_bad = 0; busy_bad = 0;
      while (!done_o && k < K_LIMIT) begin
         if (!busy_o) busy_bad = 1;
         if (mode_o != ((md == 2'd1) ? 2'd0 : md)) mode_bad = 1;
         if (pll_rst_o) rst_cnt++;
         case (kind)
            0: lock_i = (k >= 3 + d1 + lat);
            1: lock_i = (cfg_now() == oldv);
            2: lock_i = 1'b0;
            default: lock_i = 1'b1;
         endcase
         @(posedge clk);
         k++;
         @(negedge clk);
      end
      req_valid_i = 1'b0;
      check(k == ek, rq, "cycles accept to done", k, ek);
      check(err_o == exp_err, rq, "error flag at done", err_o, exp_err);
      check(cfg_now() == expv, spam ? "R2" : rq, "dividers at done", cfg_now(), expv);
      check(mode_o == md, "R3", "mux restored at done", mode_o, md);
      check(!mode_bad, (md == 2'd1) ? "R3" : "R4", "mux during request", mode_bad, 0);
      check(rst_cnt == 2 * passes, "R5", "reset cycles", rst_cnt, 2 * passes);
      check(!busy_bad, "R2", "busy during request", busy_bad, 0);
      lock_i = 1'b0;
      {m_nr, m_no, m_nf, m_nb} = expv;
      @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!busy_o && !done_o && !err_o && !pll_rst_o, "R1", "status after reset",
            {busy_o, done_o, err_o, pll_rst_o}, 0);
      check(cfg_now() == {6'(I_NR), 4'(I_NO), 13'(I_NF), 12'(I_NB)}, "R1", "dividers after reset",
            cfg_now(), {6'(I_NR), 4'(I_NO), 13'(I_NF), 12'(I_NB)});
      check(mode_o == mode_i, "R1", "mux after reset", mode_o, mode_i);

      run_req(6'd0, 4'd2, 13'd120, 12'd59, 2'd1, 3, 0, 0);          // R6 min settle, lock early
      run_req(6'd1, 4'd3, 13'd200, 12'd99, 2'd0, 0, 0, 0);          // R7 lock on first poll
      run_req(6'd2, 4'd1, 13'd150, 12'd70, 2'd2, 0, TB_TO - 1, 0);  // R7 last poll attempt
      run_req(6'd1, 4'd0, 13'd300, 12'd10, 2'd1, 1, 0, 0);          // R8 rollback succeeds
      run_req(6'd0, 4'd5, 13'd333, 12'd11, 2'd1, 2, 0, 0);          // R9 rollback times out
      run_req(6'd63, 4'd4, 13'd64, 12'd31, 2'd0, 3, 0, 0);          // R6 max settle
      run_req(6'd4, 4'd6, 13'd77, 12'd5, 2'd1, 0, 3, 1);            // R2 requests while busy

      for (int i = 0; i < 30; i++) begin
         run_req(6'($urandom_range(0, 7)), 4'($urandom_range(0, 15)),
                 13'($urandom_range(0, 8191)), 12'($urandom_range(0, 4095)),
                 2'($urandom_range(0, 2)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, TB_TO - 1)), 1'($urandom_range(0, 1)));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule